// File: doc/BRIEF.md
# LCD Panel Strobe Generator

The block derives every timing strobe a dot-matrix LCD panel needs from one system clock. Inside each line it produces a line clock, a line-latch pulse and a pixel shift clock, and it produces a frame marker on the first line of every frame. A pixel-valid strobe marks the clocks in which an external data path must place segment data on the panel bus. Four programmable fields set the timing: the bus transfer speed, an 8-bit line divisor, a 10-bit frame line count and a 3-bit front-porch count. A checker compares the divisor with the smallest legal value for the selected segment width and bus speed. An illegal setting stops the generator and raises a sticky error flag.

The panel cannot stall, so the pixel stream has no ready signal and accepts no back-pressure. The consumer must present one datum in every cycle where `pix_valid` is high, and it latches that datum on the rising edge of `pix_clk`. The configuration pins are plain levels. The block copies them into shadow registers only during reset and on the last clock of a frame, so each frame runs on a single setting from start to end.

Top module: `lcd_strobe_gen`

## Requirements
- R1: The speed code sets n = 2, 4 or 8 system clocks for codes 0, 1 and 2. `pix_clk` has a period of n clocks and is high during the second half of each period. It toggles only while `pix_valid` is high.
- R2: A line lasts 16 × (div + 1) system clocks. `line_clk` is high for the first 8 clocks of every line and low for the rest.
- R3: `line_latch` is high for the first n clocks of every line, so its width changes in steps equal to the bus speed.
- R4: A frame lasts `cfg_lines` lines. `frame_mark` is high for the whole of line 0 and low on every other line.
- R5: Lines 0 to `cfg_fporch`−1 of a frame are front-porch lines and carry no pixel data. The remaining `cfg_lines`−`cfg_fporch` lines are data lines.
- R6: Segment codes 0 to 4 select widths of 64, 128, 160, 256 and 320. On a data line, `pix_valid` is high from clock 16 of the line for width × n clocks, which gives exactly width shift-clock periods.
- R7: A setting is illegal if any of these holds:
  - div is below the minimum for its width and speed. For speeds 2/4/8 the minimums are 9/17/33 at 64, 17/33/65 at 128, 21/41/81 at 160, 33/65/129 at 256 and 41/81/161 at 320.
  - The speed code is 3.
  - The segment code is above 4.
  - `cfg_lines` ≤ `cfg_fporch`.

  An illegal shadowed setting raises `config_error` in the same cycle.
- R8: `config_error` stays high until reset. While it is high, all five strobes are low.
- R9: Configuration pins are captured during reset and on the last clock of each frame. A change at any other time first takes effect in the following frame.
- R10: Synchronous active-low reset clears all counters. In the first cycle after reset, line 0 of a new frame is under way: `line_clk`, `line_latch` and `frame_mark` are high, and `pix_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_speed | input | 2 | Bus speed code (0:2, 1:4, 2:8 clocks per shift) |
| cfg_seg | input | 3 | Segment width code (0..4) |
| cfg_div | input | 8 | Line divisor; line = 16 × (div + 1) clocks |
| cfg_lines | input | 10 | Lines per frame |
| cfg_fporch | input | 3 | Front-porch lines at frame start |
| pix_clk | output | 1 | Pixel shift clock |
| pix_valid | output | 1 | Pixel data window |
| line_clk | output | 1 | Line clock, fixed 8-clock high |
| line_latch | output | 1 | Line latch pulse, n clocks high |
| frame_mark | output | 1 | High during line 0 of each frame |
| config_error | output | 1 | Sticky illegal-setting flag |

## Verification
Every strobe is decoded combinationally from counters and shadow registers. A strobe therefore takes its new value one clock edge after the counter state it depends on, and a configuration change reaches the outputs no earlier than the first cycle of the next frame. The error flag follows the shadowed setting in the same cycle. The bench runs a predictor at each rising edge that applies the same capture rule, and it compares the predicted values against the outputs at the following falling edge. Frame-length, pixel-count and sticky-error checks count falling edges between rises of `frame_mark`, so their results do not depend on any fixed delay.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

  typedef enum logic [1:0] {
    SPD_2   = 2'd0,
    SPD_4   = 2'd1,
    SPD_8   = 2'd2,
    SPD_BAD = 2'd3
  } spd_e;

  // number of segments driven on one line; zero for an unused code
  function automatic logic [9:0] seg_width(input logic [2:0] code);
    case (code)
      3'd0:    return 10'd64;
      3'd1:    return 10'd128;
      3'd2:    return 10'd160;
      3'd3:    return 10'd256;
      3'd4:    return 10'd320;
      default: return 10'd0;
    endcase
  endfunction

  // smallest legal divisor: width * n / 16 + 1, n = 2 << spd
  function automatic logic [8:0] min_div(input logic [2:0] seg, input logic [1:0] spd);
    logic [9:0] w;
    w = seg_width(seg);
    return ({2'b00, w[9:3]} << spd) + 9'd1;
  endfunction

endpackage

// File: rtl/lcd_cfg_check.sv
module lcd_cfg_check
  import lcd_tg_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int FRM_W = 10,
  parameter int POR_W = 3
) (
  input  logic [1:0]       spd,
  input  logic [2:0]       seg,
  input  logic [DIV_W-1:0] div,
  input  logic [FRM_W-1:0] lines,
  input  logic [POR_W-1:0] fporch,
  output logic             bad
);

  localparam int CW = (DIV_W > 9) ? DIV_W : 9;

  logic [CW-1:0] div_ext, min_ext;
  logic          spd_bad, seg_bad, div_bad, frm_bad;

  always_comb begin
    div_ext = CW'(div);
    min_ext = CW'(min_div(seg, spd));
    spd_bad = (spd == SPD_BAD);
    seg_bad = (seg > 3'd4);
    div_bad = (div_ext < min_ext);
    frm_bad = (lines <= FRM_W'(fporch));
    bad     = spd_bad | seg_bad | div_bad | frm_bad;
  end

endmodule

// File: rtl/lcd_line_timer.sv
module lcd_line_timer
  import lcd_tg_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int LCLK_HI = 8,
  parameter int DATA_AT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic [1:0]       spd,
  input  logic [2:0]       seg,
  input  logic             active,
  output logic             line_end,
  output logic             line_clk,
  output logic             line_latch,
  output logic             pix_clk,
  output logic             pix_valid
);

  localparam int HW = DIV_W + 4;

  logic [HW-1:0] hcnt, last, span, off, n, phase;
  logic          in_win;

  always_comb begin
    n        = HW'(2) << spd;
    last     = {div, 4'hF};
    span     = (HW'(seg_width(seg)) << 1) << spd;
    off      = hcnt - HW'(DATA_AT);
    phase    = off & (n - HW'(1));
    in_win   = active && (hcnt >= HW'(DATA_AT)) && (off < span);
    line_end = run && (hcnt == last);
    line_clk   = run && (hcnt < HW'(LCLK_HI));
    line_latch = run && (hcnt < n);
    pix_valid  = run && in_win;
    pix_clk    = run && in_win && (phase >= (n >> 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        hcnt <= '0;
    else if (line_end) hcnt <= '0;
    else if (run)      hcnt <= hcnt + HW'(1);
  end

  a_r2_count: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !line_end) |=> (hcnt == $past(hcnt) + HW'(1)));

  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (hcnt == '0));

endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer #(
  parameter int FRM_W = 10,
  parameter int POR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             line_end,
  input  logic [FRM_W-1:0] lines,
  input  logic [POR_W-1:0] fporch,
  output logic             frame_end,
  output logic             first_line,
  output logic             active_line
);

  logic [FRM_W-1:0] vcnt;

  always_comb begin
    frame_end   = line_end && (vcnt == lines - FRM_W'(1));
    first_line  = run && (vcnt == '0);
    active_line = (vcnt >= FRM_W'(fporch));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         vcnt <= '0;
    else if (frame_end) vcnt <= '0;
    else if (line_end)  vcnt <= vcnt + FRM_W'(1);
  end

  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (vcnt == '0));

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && !frame_end) |=> (vcnt == $past(vcnt) + FRM_W'(1)));

endmodule

// File: rtl/lcd_strobe_gen.sv
module lcd_strobe_gen #(
  parameter int DIV_W   = 8,
  parameter int FRM_W   = 10,
  parameter int POR_W   = 3,
  parameter int LCLK_HI = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_speed,
  input  logic [2:0]       cfg_seg,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [FRM_W-1:0] cfg_lines,
  input  logic [POR_W-1:0] cfg_fporch,
  output logic             pix_clk,
  output logic             pix_valid,
  output logic             line_clk,
  output logic             line_latch,
  output logic             frame_mark,
  output logic             config_error
);

  logic [1:0]       sh_spd;
  logic [2:0]       sh_seg;
  logic [DIV_W-1:0] sh_div;
  logic [FRM_W-1:0] sh_lines;
  logic [POR_W-1:0] sh_fporch;
  logic             err_q, bad, run;
  logic             line_end, frame_end, active_line;

  lcd_cfg_check #(.DIV_W(DIV_W), .FRM_W(FRM_W), .POR_W(POR_W)) u_chk (
    .spd(sh_spd), .seg(sh_seg), .div(sh_div),
    .lines(sh_lines), .fporch(sh_fporch), .bad(bad)
  );

  always_comb begin
    config_error = err_q | bad;
    run          = !config_error;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_spd    <= cfg_speed;
      sh_seg    <= cfg_seg;
      sh_div    <= cfg_div;
      sh_lines  <= cfg_lines;
      sh_fporch <= cfg_fporch;
      err_q     <= 1'b0;
    end else begin
      err_q <= err_q | bad;
      if (frame_end) begin
        sh_spd    <= cfg_speed;
        sh_seg    <= cfg_seg;
        sh_div    <= cfg_div;
        sh_lines  <= cfg_lines;
        sh_fporch <= cfg_fporch;
      end
    end
  end

  lcd_line_timer #(.DIV_W(DIV_W), .LCLK_HI(LCLK_HI), .DATA_AT(16)) u_line (
    .clk(clk), .rst_n(rst_n), .run(run), .div(sh_div), .spd(sh_spd),
    .seg(sh_seg), .active(active_line), .line_end(line_end),
    .line_clk(line_clk), .line_latch(line_latch),
    .pix_clk(pix_clk), .pix_valid(pix_valid)
  );

  lcd_frame_timer #(.FRM_W(FRM_W), .POR_W(POR_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .run(run), .line_end(line_end),
    .lines(sh_lines), .fporch(sh_fporch), .frame_end(frame_end),
    .first_line(frame_mark), .active_line(active_line)
  );

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    config_error |-> !(pix_clk | pix_valid | line_clk | line_latch | frame_mark));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable({sh_spd, sh_seg, sh_div, sh_lines, sh_fporch}));

endmodule

// File: tb/sim_lcd_strobe_gen.sv
`timescale 1ns/1ps
module sim_lcd_strobe_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_speed = 2'd0;
  logic [2:0] cfg_seg = 3'd0;
  logic [7:0] cfg_div = 8'd9;
  logic [9:0] cfg_lines = 10'd5;
  logic [2:0] cfg_fporch = 3'd2;
  logic pix_clk, pix_valid, line_clk, line_latch, frame_mark, config_error;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lcd_strobe_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_speed(cfg_speed), .cfg_seg(cfg_seg),
    .cfg_div(cfg_div), .cfg_lines(cfg_lines), .cfg_fporch(cfg_fporch),
    .pix_clk(pix_clk), .pix_valid(pix_valid), .line_clk(line_clk),
    .line_latch(line_latch), .frame_mark(frame_mark), .config_error(config_error)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  // values taken from the requirements
  function automatic int t_width(input int code);
    case (code)
      0: return 64;  1: return 128; 2: return 160;
      3: return 256; 4: return 320; default: return 0;
    endcase
  endfunction

  function automatic int t_speed(input int code);
    case (code)
      0: return 2; 1: return 4; 2: return 8; default: return 0;
    endcase
  endfunction

  function automatic int t_min(input int seg, input int spd);
    case ({seg[2:0], spd[1:0]})
      {3'd0,2'd0}: return 9;   {3'd0,2'd1}: return 17;  {3'd0,2'd2}: return 33;
      {3'd1,2'd0}: return 17;  {3'd1,2'd1}: return 33;  {3'd1,2'd2}: return 65;
      {3'd2,2'd0}: return 21;  {3'd2,2'd1}: return 41;  {3'd2,2'd2}: return 81;
      {3'd3,2'd0}: return 33;  {3'd3,2'd1}: return 65;  {3'd3,2'd2}: return 129;
      {3'd4,2'd0}: return 41;  {3'd4,2'd1}: return 81;  {3'd4,2'd2}: return 161;
      default: return 1000;
    endcase
  endfunction

  function automatic bit t_bad(input int spd, input int seg, input int dv,
                               input int ln, input int fp);
    if (spd == 3 || seg > 4) return 1'b1;
    if (dv < t_min(seg, spd)) return 1'b1;
    return (ln <= fp);
  endfunction

  // ---------------- predictor / scoreboard ----------------
  typedef struct packed {
    logic pc; logic lc; logic ll; logic fm; logic pv; logic er;
  } exp_t;
  exp_t q[$];

  int m_h = 0, m_v = 0, m_spd = 0, m_seg = 0, m_div = 0, m_ln = 0, m_fp = 0;
  bit m_err = 1'b0;

  always @(posedge clk) begin
    exp_t e;
    bit   run, bd;
    int   n, w, off;
    if (!rst_n) begin
      m_h = 0; m_v = 0; m_err = 1'b0;
      m_spd = cfg_speed; m_seg = cfg_seg; m_div = cfg_div;
      m_ln = cfg_lines; m_fp = cfg_fporch;
    end else begin
      bd  = t_bad(m_spd, m_seg, m_div, m_ln, m_fp);
      run = !(m_err || bd);
      m_err = m_err || bd;
      if (run) begin
        if (m_h == 16 * (m_div + 1) - 1) begin
          m_h = 0;
          if (m_v == m_ln - 1) begin
            m_v = 0;
            m_spd = cfg_speed; m_seg = cfg_seg; m_div = cfg_div;
            m_ln = cfg_lines; m_fp = cfg_fporch;
          end else m_v = m_v + 1;
        end else m_h = m_h + 1;
      end
    end
    bd  = t_bad(m_spd, m_seg, m_div, m_ln, m_fp);
    run = !(m_err || bd);
    n   = t_speed(m_spd);
    w   = t_width(m_seg);
    off = m_h - 16;
    e.er = m_err || bd;
    e.lc = run && (m_h < 8);
    e.ll = run && (m_h < n);
    e.fm = run && (m_v == 0);
    e.pv = run && (m_v >= m_fp) && (m_h >= 16) && (off < w * n);
    e.pc = e.pv && (n > 0) && ((off % (n > 0 ? n : 1)) >= n / 2);
    q.push_back(e);
  end

  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk("R1 pix_clk",         pix_clk,      e.pc);
      chk("R2 line_clk",        line_clk,     e.lc);
      chk("R3 line_latch",      line_latch,   e.ll);
      chk("R4 frame_mark",      frame_mark,   e.fm);
      chk("R6 pix_valid",       pix_valid,    e.pv);
      chk("R7 config_error",    config_error, e.er);
    end
  end

  // ---------------- driver tasks ----------------
  task automatic set_cfg(input int spd, input int seg, input int dv,
                         input int ln, input int fp);
    @(negedge clk);
    cfg_speed = spd[1:0]; cfg_seg = seg[2:0]; cfg_div = dv[7:0];
    cfg_lines = ln[9:0]; cfg_fporch = fp[2:0];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_frame_start();
    logic last;
    last = frame_mark;
    forever begin
      @(negedge clk);
      if (frame_mark && !last) break;
      last = frame_mark;
    end
  endtask

  task automatic measure_to_next(output int cyc, output int rises, output int vcyc);
    logic last, pclast;
    cyc = 0; rises = 0; vcyc = 0;
    last = frame_mark; pclast = pix_clk;
    forever begin
      @(negedge clk);
      cyc++;
      if (frame_mark && !last) break;
      last = frame_mark;
      if (pix_valid) vcyc++;
      if (pix_clk && !pclast) rises++;
      pclast = pix_clk;
    end
  endtask

  task automatic frame_scenario(input int spd, input int seg, input int dv,
                                input int ln, input int fp);
    int cyc, rs, vc, n, w;
    n = t_speed(spd); w = t_width(seg);
    set_cfg(spd, seg, dv, ln, fp);
    do_reset();
    chk("R10 line_clk after reset",   line_clk,   1);
    chk("R10 frame_mark after reset", frame_mark, 1);
    chk("R10 pix_valid after reset",  pix_valid,  0);
    wait_frame_start();
    measure_to_next(cyc, rs, vc);
    chk("R4 frame length", cyc, 16 * (dv + 1) * ln);
    chk("R6 shift clocks per frame", rs, (ln - fp) * w);
    chk("R5 valid cycles per frame", vc, (ln - fp) * w * n);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    int cyc, rs, vc;

    // R1..R6, R10 under three bus speeds and widths
    frame_scenario(0, 0, 9, 5, 2);
    frame_scenario(1, 2, 41, 4, 1);
    frame_scenario(2, 4, 161, 3, 0);

    // R9: a mid-frame change waits for the frame boundary
    set_cfg(0, 0, 9, 5, 2);
    do_reset();
    wait_frame_start();
    cfg_div = 8'd20;
    measure_to_next(cyc, rs, vc);
    chk("R9 old setting kept to frame end", cyc, 16 * 10 * 5);
    measure_to_next(cyc, rs, vc);
    chk("R9 new setting in next frame", cyc, 16 * 21 * 5);

    // R7: minimum divisor table, both sides of every bound
    for (int sg = 0; sg < 5; sg++) begin
      for (int sp = 0; sp < 3; sp++) begin
        set_cfg(sp, sg, t_min(sg, sp) - 1, 4, 1);
        do_reset();
        chk("R7 below minimum flags", config_error, 1);
        chk("R8 strobes low in error", line_clk, 0);
        set_cfg(sp, sg, t_min(sg, sp), 4, 1);
        do_reset();
        chk("R7 at minimum is legal", config_error, 0);
      end
    end

    // R7: illegal codes and frame shape
    set_cfg(3, 0, 200, 4, 1); do_reset();
    chk("R7 speed code 3", config_error, 1);
    set_cfg(0, 5, 200, 4, 1); do_reset();
    chk("R7 segment code 5", config_error, 1);
    set_cfg(0, 0, 9, 3, 3); do_reset();
    chk("R7 lines not above porch", config_error, 1);

    // R8: sticky across a later legal setting
    set_cfg(0, 0, 9, 5, 2);
    repeat (300) @(negedge clk);
    chk("R8 error stays set", config_error, 1);
    chk("R8 frame_mark held low", frame_mark, 0);

    // R8: illegal setting loaded at a frame boundary during run
    set_cfg(0, 0, 9, 4, 1); do_reset();
    chk("R8 legal before change", config_error, 0);
    cfg_div = 8'd3;
    repeat (700) @(negedge clk);
    chk("R8 error after frame boundary", config_error, 1);
    cfg_div = 8'd9;
    repeat (200) @(negedge clk);
    chk("R8 error still set", config_error, 1);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule